// File: doc/BRIEF.md
# UART Modem Loopback Controller

This block sits between a UART serial core and the device pins. It holds the modem control register and the modem status register. It steers the serial line and the four modem status lines either to the pins (normal operation) or through an internal diagnostic loop.

In loopback, the transmitter's serial stream goes straight back into the receiver. The external status pins are ignored. The four modem control bits stand in for the status inputs, so software can exercise the whole status and interrupt path without external wiring.

External status inputs are synchronized first. Change events are then latched as sticky delta bits in the low nibble of the status register, and reading that register clears them. A modem-status interrupt is raised while any delta bit is set and the interrupt is enabled.

Top module: `modem_loop_ctl`

## Requirements
- R1: Control register bit 4 selects loopback. In loopback, `pin_txd` is 1 and `core_rxd` equals `core_txd`. In normal mode, `pin_txd` equals `core_txd` and `core_rxd` equals `pin_rxd`.
- R2: In normal mode the active-low outputs are the inverse of control bits 0 to 3:
  - bit 0 drives `pin_dtr_n`
  - bit 1 drives `pin_rts_n`
  - bit 2 drives `pin_out1_n`
  - bit 3 drives `pin_out2_n`
  
  In loopback, all four outputs are held at 1.
- R3: In loopback, the levels of `pin_cts_n`, `pin_dsr_n`, `pin_dcd_n` and `pin_ri_n` have no effect on the status register or on `msi_irq`.
- R4: In loopback, status register bits 4 to 7 are fed from control register bits, one cycle after the control register is written:
  - bit 4 (CTS) takes bit 0
  - bit 5 (DSR) takes bit 1
  - bit 6 (RI) takes bit 2
  - bit 7 (DCD) takes bit 3
- R5: In normal mode, status bits 4 to 7 show the inverted levels of `pin_cts_n`, `pin_dsr_n`, `pin_ri_n` and `pin_dcd_n`. A level present at a rising edge appears after the second following rising edge.
- R6: Status bits 0, 1 and 3 set on any change of CTS, DSR or DCD status respectively. Bit 2 sets only when RI status goes from 1 to 0. All four bits stay set until cleared.
- R7: A read of the status register (`reg_rd` with `reg_sel`=1) clears bits 0 to 3 at that edge. An event detected at the same edge remains set.
- R8: `msi_irq` is 1 exactly when `msi_en` is 1 and any of status bits 0 to 3 is set.
- R9: Entering or leaving loopback sets no delta bit, even when the newly selected status sources differ from the old ones.
- R10: `reg_sel`=0 addresses the control register and `reg_sel`=1 the status register.
  - `reg_rdata` is combinational.
  - The control register reads as {3'b0, bits 4:0}.
  - After reset, both registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | 0: control register, 1: status register |
| reg_wr | input | 1 | Write strobe (control register only) |
| reg_rd | input | 1 | Read strobe, clears deltas when status selected |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data |
| msi_en | input | 1 | Modem-status interrupt enable |
| msi_irq | output | 1 | Modem-status interrupt |
| core_txd | input | 1 | Serial data from the transmitter |
| core_rxd | output | 1 | Serial data to the receiver |
| pin_txd | output | 1 | Transmit pin |
| pin_rxd | input | 1 | Receive pin |
| pin_cts_n | input | 1 | Clear-to-send pin, active low |
| pin_dsr_n | input | 1 | Data-set-ready pin, active low |
| pin_dcd_n | input | 1 | Carrier-detect pin, active low |
| pin_ri_n | input | 1 | Ring-indicator pin, active low |
| pin_dtr_n | output | 1 | Terminal-ready pin, active low |
| pin_rts_n | output | 1 | Request-to-send pin, active low |
| pin_out1_n | output | 1 | General output 1, active low |
| pin_out2_n | output | 1 | General output 2, active low |

## Verification
The assertions assume the status pins are held inactive (high) while reset is applied, so the synchronizer comes up with no pending change. The stimulus honours this and only moves the pins after reset is released. The assertions also assume register strobes are single-cycle pulses aligned to the clock. The bench changes every input only on the falling edge, including random control register writes that toggle loopback mid-stream.

// File: rtl/modem_loop_pkg.sv
package modem_loop_pkg;

  localparam int MDM_W = 4;

  // bit order matches status register bits 7:4 (dcd is msb)
  typedef struct packed {
    logic dcd;
    logic ri;
    logic dsr;
    logic cts;
  } mdm_stat_t;

  // loopback crosswiring: control bits 0..3 feed cts, dsr, ri, dcd
  function automatic mdm_stat_t loop_map(input logic [MDM_W-1:0] ctl);
    mdm_stat_t s;
    s.cts = ctl[0];
    s.dsr = ctl[1];
    s.ri  = ctl[2];
    s.dcd = ctl[3];
    return s;
  endfunction

  // pins packed {dcd_n, ri_n, dsr_n, cts_n}, active low
  function automatic mdm_stat_t pin_map(input logic [MDM_W-1:0] pins_n);
    return mdm_stat_t'(~pins_n);
  endfunction

  // delta bits: 0 cts change, 1 dsr change, 2 ri trailing edge, 3 dcd change
  function automatic logic [MDM_W-1:0] delta_of(input mdm_stat_t old_s,
                                                input mdm_stat_t new_s);
    logic [MDM_W-1:0] d;
    d[0] = old_s.cts ^ new_s.cts;
    d[1] = old_s.dsr ^ new_s.dsr;
    d[2] = old_s.ri & ~new_s.ri;
    d[3] = old_s.dcd ^ new_s.dcd;
    return d;
  endfunction

endpackage

// File: rtl/modem_sync.sv
module modem_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [STAGES-1:0][W-1:0] chain_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= '1;
          else        chain_q[g] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= '1;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/modem_path_mux.sv
module modem_path_mux #(
  parameter int CTL_W = 4
) (
  input  logic             loop_en,
  input  logic             core_txd,
  input  logic             pin_rxd,
  input  logic [CTL_W-1:0] ctl_bits,
  output logic             pin_txd,
  output logic             core_rxd,
  output logic [CTL_W-1:0] ctl_pins_n
);
  localparam logic [CTL_W-1:0] IDLE_N = '1;

  always_comb begin
    if (loop_en) begin
      pin_txd    = 1'b1;
      core_rxd   = core_txd;
      ctl_pins_n = IDLE_N;
    end else begin
      pin_txd    = core_txd;
      core_rxd   = pin_rxd;
      ctl_pins_n = ~ctl_bits;
    end
  end
endmodule

// File: rtl/modem_status_reg.sv
module modem_status_reg
  import modem_loop_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             loop_en,
  input  logic [MDM_W-1:0] ctl_bits,
  input  logic [MDM_W-1:0] pins_sync_n,
  input  logic             rd_clr,
  input  logic             msi_en,
  output mdm_stat_t        stat_q,
  output logic [MDM_W-1:0] delta_q,
  output logic             irq
);
  logic             loop_d;
  logic             mode_chg;
  mdm_stat_t        src;
  logic [MDM_W-1:0] delta_ev;
  logic [MDM_W-1:0] delta_nx;

  assign mode_chg = loop_en != loop_d;
  assign src      = loop_en ? loop_map(ctl_bits) : pin_map(pins_sync_n);
  assign delta_ev = mode_chg ? '0 : delta_of(stat_q, src);
  assign delta_nx = (rd_clr ? '0 : delta_q) | delta_ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loop_d  <= 1'b0;
      stat_q  <= '0;
      delta_q <= '0;
    end else begin
      loop_d  <= loop_en;
      stat_q  <= src;
      delta_q <= delta_nx;
    end
  end

  assign irq = msi_en & (|delta_q);

  // R9
  mode_switch_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |=> ((delta_q & ~$past(delta_q)) == '0));

  // R7
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && delta_ev == '0) |=> (delta_q == '0));

  // R6
  ri_trailing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(delta_q[2]) |-> ($past(stat_q.ri) && !stat_q.ri));

  // R6
  delta_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_clr) |=> ((delta_q & $past(delta_q)) == $past(delta_q)));
endmodule

// File: rtl/modem_loop_ctl.sv
module modem_loop_ctl
  import modem_loop_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_sel,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              msi_en,
  output logic              msi_irq,
  input  logic              core_txd,
  output logic              core_rxd,
  output logic              pin_txd,
  input  logic              pin_rxd,
  input  logic              pin_cts_n,
  input  logic              pin_dsr_n,
  input  logic              pin_dcd_n,
  input  logic              pin_ri_n,
  output logic              pin_dtr_n,
  output logic              pin_rts_n,
  output logic              pin_out1_n,
  output logic              pin_out2_n
);
  localparam int CTL_W   = MDM_W + 1;
  localparam int LOOP_B  = MDM_W;
  localparam int PAD_W   = DATA_W - CTL_W;

  logic [CTL_W-1:0] ctl_q;
  logic             loop_en;
  logic             rd_clr;
  logic [MDM_W-1:0] pins_raw_n;
  logic [MDM_W-1:0] pins_sync_n;
  logic [MDM_W-1:0] ctl_pins_n;
  mdm_stat_t        stat_q;
  logic [MDM_W-1:0] delta_q;

  assign loop_en    = ctl_q[LOOP_B];
  assign rd_clr     = reg_rd & reg_sel;
  assign pins_raw_n = {pin_dcd_n, pin_ri_n, pin_dsr_n, pin_cts_n};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 ctl_q <= '0;
    else if (reg_wr && !reg_sel) ctl_q <= reg_wdata[CTL_W-1:0];
  end

  modem_sync #(.W(MDM_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (pins_raw_n),
    .dout  (pins_sync_n)
  );

  modem_path_mux #(.CTL_W(MDM_W)) u_mux (
    .loop_en    (loop_en),
    .core_txd   (core_txd),
    .pin_rxd    (pin_rxd),
    .ctl_bits   (ctl_q[MDM_W-1:0]),
    .pin_txd    (pin_txd),
    .core_rxd   (core_rxd),
    .ctl_pins_n (ctl_pins_n)
  );

  assign pin_dtr_n  = ctl_pins_n[0];
  assign pin_rts_n  = ctl_pins_n[1];
  assign pin_out1_n = ctl_pins_n[2];
  assign pin_out2_n = ctl_pins_n[3];

  modem_status_reg u_stat (
    .clk         (clk),
    .rst_n       (rst_n),
    .loop_en     (loop_en),
    .ctl_bits    (ctl_q[MDM_W-1:0]),
    .pins_sync_n (pins_sync_n),
    .rd_clr      (rd_clr),
    .msi_en      (msi_en),
    .stat_q      (stat_q),
    .delta_q     (delta_q),
    .irq         (msi_irq)
  );

  assign reg_rdata = reg_sel ? {stat_q, delta_q} : {{PAD_W{1'b0}}, ctl_q};

  // R1
  loop_serial_chk: assert property (@(posedge clk) disable iff (!rst_n)
    loop_en |-> (pin_txd && core_rxd == core_txd));

  // R2
  loop_outs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    loop_en |-> (pin_dtr_n && pin_rts_n && pin_out1_n && pin_out2_n));

  // R3
  loop_pins_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(loop_en) |-> (stat_q == loop_map($past(ctl_q[MDM_W-1:0]))));

  // R8
  irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msi_irq |-> (msi_en && delta_q != '0));
endmodule

// File: tb/tb_modem_loop_ctl.sv
`timescale 1ns/1ps
module tb_modem_loop_ctl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_sel = 1'b0, reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       msi_en = 1'b0, msi_irq;
  logic       core_txd = 1'b1, core_rxd, pin_txd, pin_rxd = 1'b1;
  logic       pin_cts_n = 1'b1, pin_dsr_n = 1'b1, pin_dcd_n = 1'b1, pin_ri_n = 1'b1;
  logic       pin_dtr_n, pin_rts_n, pin_out1_n, pin_out2_n;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  modem_loop_ctl dut (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .msi_en(msi_en), .msi_irq(msi_irq),
    .core_txd(core_txd), .core_rxd(core_rxd), .pin_txd(pin_txd), .pin_rxd(pin_rxd),
    .pin_cts_n(pin_cts_n), .pin_dsr_n(pin_dsr_n), .pin_dcd_n(pin_dcd_n), .pin_ri_n(pin_ri_n),
    .pin_dtr_n(pin_dtr_n), .pin_rts_n(pin_rts_n), .pin_out1_n(pin_out1_n), .pin_out2_n(pin_out2_n)
  );

  // reference model state
  logic [4:0] m_ctl;
  logic [3:0] m_msr_hi;     // {dcd, ri, dsr, cts}
  logic [3:0] m_msr_lo;     // deltas
  logic       m_loop_prev;
  logic [3:0] m_pipe [$];   // synchronizer contents, oldest first

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_ctl = 0; m_msr_hi = 0; m_msr_lo = 0; m_loop_prev = 0;
    m_pipe = {4'hF, 4'hF};
  endtask

  initial model_reset();

  // model advances on every rising edge, comparison shortly after
  always @(posedge clk) begin
    logic [3:0] src, ev;
    if (!rst_n) model_reset();
    else begin
      src = m_ctl[4] ? m_ctl[3:0] : ~m_pipe[0];
      ev  = 4'h0;
      if (m_ctl[4] == m_loop_prev) begin
        for (int i = 0; i < 4; i++) begin
          if (i == 2) ev[i] = m_msr_hi[i] && !src[i];
          else        ev[i] = m_msr_hi[i] != src[i];
        end
      end
      if (reg_rd && reg_sel) m_msr_lo = 4'h0;
      m_msr_lo    = m_msr_lo | ev;
      m_msr_hi    = src;
      m_loop_prev = m_ctl[4];
      void'(m_pipe.pop_front());
      m_pipe.push_back({pin_dcd_n, pin_ri_n, pin_dsr_n, pin_cts_n});
      if (reg_wr && !reg_sel) m_ctl = reg_wdata[4:0];
    end
    #3;
    if (rst_n) begin
      bit lp;
      logic [7:0] exp_rd;
      logic [3:0] exp_outs, act_outs;
      lp = m_ctl[4];
      // R1
      check(pin_txd == (lp ? 1'b1 : core_txd) && core_rxd == (lp ? core_txd : pin_rxd),
            "R1 serial path", {pin_txd, core_rxd}, {lp ? 1'b1 : core_txd, lp ? core_txd : pin_rxd});
      // R2
      exp_outs = lp ? 4'hF : ~m_ctl[3:0];
      act_outs = {pin_out2_n, pin_out1_n, pin_rts_n, pin_dtr_n};
      check(act_outs == exp_outs, "R2 modem outputs", act_outs, exp_outs);
      // R3 R4 R5 R6 R7 R9 R10 via the register view
      exp_rd = reg_sel ? {m_msr_hi, m_msr_lo} : {3'b000, m_ctl};
      check(reg_rdata == exp_rd, "R3/R4/R5/R6/R7/R9/R10 register read", reg_rdata, exp_rd);
      // R8
      check(msi_irq == (msi_en && m_msr_lo != 0), "R8 interrupt", msi_irq, msi_en && m_msr_lo != 0);
    end
  end

  task automatic wr_ctl(input logic [7:0] v);
    @(negedge clk); reg_sel = 0; reg_wr = 1; reg_wdata = v;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd_msr();
    @(negedge clk); reg_sel = 1; reg_rd = 1;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    idle(4);
    @(negedge clk) rst_n = 1;
    // R10 reset values
    #1; reg_sel = 0; #1; check(reg_rdata == 8'h00, "R10 reset control", reg_rdata, 0);
    reg_sel = 1; #1; check(reg_rdata == 8'h00, "R10 reset status", reg_rdata, 0);
    msi_en = 1;
    // R2 normal outputs
    wr_ctl(8'h05); idle(2); wr_ctl(8'h0A); idle(2);
    // R5 R6 pin changes in normal mode, including RI both edges
    @(negedge clk) pin_cts_n = 0; idle(4);
    @(negedge clk) pin_ri_n = 0; idle(4);
    @(negedge clk) pin_ri_n = 1; idle(4);
    rd_msr(); idle(2);
    // R9 switch into loopback with differing sources
    wr_ctl(8'h13); idle(3);
    // R3 pins wiggle in loopback
    @(negedge clk) begin pin_dsr_n = 0; pin_dcd_n = 0; pin_cts_n = 1; end idle(4);
    // R4 loop crosswiring and RI trailing edge from control bit 2
    wr_ctl(8'h1C); idle(2); wr_ctl(8'h18); idle(2);
    // R7 clear and R1 serial loop
    rd_msr();
    repeat (8) begin @(negedge clk) begin core_txd = ~core_txd; pin_rxd = $urandom_range(0, 1); end end
    wr_ctl(8'h00); idle(3); rd_msr();
    // random phase
    for (int c = 0; c < 4000; c++) begin
      @(negedge clk);
      core_txd = $urandom_range(0, 1);
      pin_rxd  = $urandom_range(0, 1);
      if ($urandom_range(0, 7) == 0) pin_cts_n = ~pin_cts_n;
      if ($urandom_range(0, 7) == 0) pin_dsr_n = ~pin_dsr_n;
      if ($urandom_range(0, 7) == 0) pin_dcd_n = ~pin_dcd_n;
      if ($urandom_range(0, 7) == 0) pin_ri_n  = ~pin_ri_n;
      if ($urandom_range(0, 15) == 0) msi_en = ~msi_en;
      reg_sel = $urandom_range(0, 1);
      reg_wr  = ($urandom_range(0, 9) == 0);
      reg_rd  = ($urandom_range(0, 5) == 0);
      reg_wdata = $urandom_range(0, 255);
    end
    @(negedge clk) begin reg_wr = 0; reg_rd = 0; end
    idle(4);
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end
endmodule